// File: doc/BRIEF.md
# Dot-Matrix Row Refresh Scanner

This block refreshes one four-character section of a 5x7 LED dot-matrix display. The host writes a 160-bit dot image in one parallel write. The block keeps that image in a pending copy and moves it into the shadow copy that the scanner reads only at the end of a frame. The scanner lights the display one row at a time and drives all 20 column enables of the active row together.

The scan is paced by an oscillator tick. The tick comes either from rising edges on an external oscillator pin or from an internal divider on the system clock. An optional divide-by-8 prescaler can slow the selected tick. A frame has 8 row slots of 64 ticks each, so it lasts 512 ticks. Brightness is set by a 6-bit on-cycle count: within each slot, columns are driven only during the first `on_cycles` ticks, which gives a duty of (1/8)*(on_cycles/64).

Top module: `dot_scanner`

## Requirements
- R1: A synchronous active-low reset sets `row_sel` to 8'b00000001, turns all of `col_en` off and clears both the shadow and the pending dot image. After reset the display stays dark at any brightness until a new image is loaded and a frame boundary has passed.
- R2: The image is 20 column bytes. The dot of column c in row r is bit 8*c+r of `dot_data`, and it drives `col_en[c]` while row r is active.
- R3: `row_sel` is one-hot. The scan starts in row 0 and steps up by one row after every 64 scan ticks, in the order 0 to 7 and then back to 0, so a frame is 512 scan ticks.
- R4: Within a row slot, `col_en[c]` is high only while the slot tick index (0 to 63) is below `on_cycles`.
- R5: When `on_cycles` is 0, `col_en` stays all zero.
- R6: Row slot 7 is always dark: `col_en` is 0 while `row_sel[7]` is high, whatever bit 7 of each column byte holds.
- R7: With `osc_sel`=1, each rising edge of `ext_osc` seen in the clock domain is one source tick. With `osc_sel`=0, one source tick occurs every INT_DIV clock cycles, counted from reset.
- R8: With `prescale_en`=1, only every 8th source tick is a scan tick. With `prescale_en`=0, every source tick is a scan tick.
- R9: A `load` pulse captures `dot_data` into the pending copy. The displayed image changes only on the scan tick that ends a frame, and the most recent load before that tick is the one shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_sel | input | 1 | 1: external oscillator, 0: internal divider |
| ext_osc | input | 1 | External oscillator level |
| prescale_en | input | 1 | Enables the divide-by-8 prescaler |
| on_cycles | input | 6 | Ticks per row slot during which columns are driven |
| load | input | 1 | Capture `dot_data` into the pending image |
| dot_data | input | 160 | Dot image, column-byte layout |
| row_sel | output | 8 | One-hot active row slot |
| col_en | output | 20 | Column driver enables |

## Verification
Random images with random brightness values are scanned from the internal source, which tests the bit layout and the on-cycle window in every row. The same scan is repeated from an external oscillator with random edge spacing, and again with the prescaler enabled; these runs show whether the source select and the tick division change the slot timing. An image loaded in the middle of a frame is checked against the previous image until the frame wraps, which catches any early update of the displayed image. A blank brightness setting and the always-dark eighth row are also checked against an all-ones image, so that a dark output cannot come from missing data.

// File: rtl/dot_scanner.sv
module dot_scanner #(
  parameter int NUM_COLS    = 20,
  parameter int NUM_SLOTS   = 8,
  parameter int LIT_ROWS    = 7,
  parameter int SLOT_CYCLES = 64,
  parameter int PRESCALE    = 8,
  parameter int INT_DIV     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          osc_sel,
  input  logic                          ext_osc,
  input  logic                          prescale_en,
  input  logic [$clog2(SLOT_CYCLES)-1:0] on_cycles,
  input  logic                          load,
  input  logic [NUM_COLS*8-1:0]         dot_data,
  output logic [NUM_SLOTS-1:0]          row_sel,
  output logic [NUM_COLS-1:0]           col_en
);
  localparam int CYC_W = $clog2(SLOT_CYCLES);
  localparam int ROW_W = $clog2(NUM_SLOTS);
  localparam int POS_W = CYC_W + ROW_W;
  localparam int IMG_W = NUM_COLS * 8;
  localparam int PRE_W = $clog2(PRESCALE);
  localparam int DIV_W = $clog2(INT_DIV) + 1;

  logic             ext_q;
  logic [DIV_W-1:0] int_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic [POS_W-1:0] pos;
  logic [IMG_W-1:0] pend, shadow;
  logic             pend_v;

  wire [ROW_W-1:0] row = pos[POS_W-1:CYC_W];
  wire [CYC_W-1:0] cyc = pos[CYC_W-1:0];

  wire int_tick   = (int_cnt == DIV_W'(INT_DIV - 1));
  wire raw_tick   = osc_sel ? (ext_osc & ~ext_q) : int_tick;
  wire scan_tick  = raw_tick && (!prescale_en || pre_cnt == PRE_W'(PRESCALE - 1));
  wire frame_wrap = scan_tick && (pos == POS_W'(NUM_SLOTS * SLOT_CYCLES - 1));
  wire window     = (cyc < on_cycles) && (int'(row) < LIT_ROWS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      int_cnt <= '0;
      pre_cnt <= '0;
      pos     <= '0;
    end else begin
      ext_q   <= ext_osc;
      int_cnt <= int_tick ? '0 : int_cnt + 1'b1;
      if (!prescale_en)
        pre_cnt <= '0;
      else if (raw_tick)
        pre_cnt <= (pre_cnt == PRE_W'(PRESCALE - 1)) ? '0 : pre_cnt + 1'b1;
      if (scan_tick)
        pos <= frame_wrap ? '0 : pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      pend_v <= 1'b0;
      shadow <= '0;
    end else begin
      if (frame_wrap && pend_v) shadow <= pend;
      if (load) begin
        pend   <= dot_data;
        pend_v <= 1'b1;
      end else if (frame_wrap) begin
        pend_v <= 1'b0;
      end
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_COLS; c++) begin : g_col
      assign col_en[c] = window && shadow[c*8 + int'(row)];
    end
  endgenerate

  assign row_sel = NUM_SLOTS'(1) << row;

  assert_reset_dark_R1: assert property (@(posedge clk)
    !rst_n |=> (col_en == '0) && (row_sel == NUM_SLOTS'(1)));
  assert_pos_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(pos));
  assert_blank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (on_cycles == '0) |-> (col_en == '0));
  assert_dark_row7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_sel[NUM_SLOTS-1] |-> (col_en == '0));
  assert_image_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(shadow));
endmodule

// File: tb/test_dot_scanner.sv
`timescale 1ns/1ps
module test_dot_scanner;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, osc_sel = 0, ext_osc = 0, prescale_en = 0, load = 0;
  logic [5:0] on_cycles = 0;
  logic [159:0] dot_data = '0;
  logic [7:0] row_sel;
  logic [19:0] col_en;
  int tests = 0, fails = 0;
  string cur_req = "R3";

  // reference state
  int m_div, m_pre, m_pos; bit m_ext, m_pv;
  logic [159:0] m_pend, m_shadow;

  dot_scanner #(.INT_DIV(DIV)) i_dot_scanner (.*);

  always #2.5 clk = ~clk;

  function automatic logic [19:0] exp_cols(logic [159:0] img, int pos, int on);
    logic [19:0] r = '0;
    int row = pos / 64, cyc = pos % 64;
    for (int c = 0; c < 20; c++) r[c] = (row < 7) && (cyc < on) && img[c*8 + row];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [159:0] act, logic [159:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit raw, scan, wrap;
    if (!rst_n) begin
      m_div = 0; m_pre = 0; m_pos = 0; m_ext = 0; m_pv = 0; m_pend = '0; m_shadow = '0;
      return;
    end
    raw  = osc_sel ? (ext_osc && !m_ext) : (m_div == DIV - 1);
    scan = raw && (!prescale_en || m_pre == 7);
    wrap = scan && m_pos == 511;
    m_ext = ext_osc;
    m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
    if (!prescale_en) m_pre = 0; else if (raw) m_pre = (m_pre + 1) % 8;
    if (wrap && m_pv) m_shadow = m_pend;
    if (load) begin m_pend = dot_data; m_pv = 1; end else if (wrap) m_pv = 0;
    if (scan) m_pos = (m_pos + 1) % 512;
  endtask

  task automatic step(bit compare);
    @(posedge clk); model_edge();
    @(negedge clk);
    if (compare) begin
      chk(row_sel == (8'd1 << (m_pos / 64)), "R3", 160'(row_sel), 160'(8'd1 << (m_pos / 64)));
      chk(col_en == exp_cols(m_shadow, m_pos, on_cycles), cur_req, 160'(col_en),
          160'(exp_cols(m_shadow, m_pos, on_cycles)));
    end
  endtask

  task automatic run(int n, int ext_half);
    int k = 0;
    for (int i = 0; i < n; i++) begin
      if (osc_sel && ++k >= ext_half) begin ext_osc = ~ext_osc; k = 0; end
      step(1);
      load = 0;
    end
  endtask

  task automatic do_load(logic [159:0] v);
    dot_data = v; load = 1;
  endtask

  function automatic logic [159:0] rnd_img();
    logic [159:0] v;
    for (int i = 0; i < 5; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [159:0] a, b;
    void'($urandom(32'h5eed1234));
    step(0); step(0);
    chk(row_sel == 8'h01 && col_en == '0, "R1", 160'({row_sel, col_en}), 160'({8'h01, 20'h0}));
    rst_n = 1; on_cycles = 63;
    cur_req = "R1"; run(3000, 0);
    chk(col_en == '0, "R1", 160'(col_en), 160'(0));

    cur_req = "R2"; a = rnd_img(); do_load(a); run(2200, 0);
    for (int j = 0; j < 3; j++) begin
      on_cycles = 6'($urandom_range(1, 63));
      cur_req = "R4"; run(2100, 0);
    end

    on_cycles = 63; b = ~a; do_load(b); step(1); load = 0;
    chk(col_en == exp_cols(a, m_pos, 63), "R9", 160'(col_en), 160'(exp_cols(a, m_pos, 63)));
    cur_req = "R9"; do_load(rnd_img()); run(10, 0); do_load(b); run(2100, 0);
    chk(m_shadow == b, "R9", 160'(col_en), 160'(0));

    do_load({160{1'b1}}); on_cycles = 63; cur_req = "R6"; run(2100, 0);
    on_cycles = 0; cur_req = "R5"; run(2100, 0);
    chk(col_en == '0, "R5", 160'(col_en), 160'(0));

    on_cycles = 40; osc_sel = 1; do_load(rnd_img()); cur_req = "R7";
    for (int j = 0; j < 3; j++) run(1400, $urandom_range(1, 4));
    osc_sel = 0; prescale_en = 1; cur_req = "R8"; do_load(rnd_img());
    run(34000, 0);
    prescale_en = 0; cur_req = "R2"; run(2100, 0);

    rst_n = 0; step(0); step(1);
    chk(row_sel == 8'h01 && col_en == '0, "R1", 160'({row_sel, col_en}), 160'({8'h01, 20'h0}));
    rst_n = 1; on_cycles = 63; cur_req = "R1"; run(2100, 0);
    chk(col_en == '0, "R1", 160'(col_en), 160'(0));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule